// File: doc/BRIEF.md
# SDRAM Idle Sleep and Self-Refresh Controller

This block decides when the main SDRAM controller may stop its clock and when the memory must stay in self-refresh. It counts consecutive idle memory-clock cycles. When both the controller's own power-management enable and an external power-management enable are high, and the count reaches a programmed threshold, the block enters sleep. In sleep it raises a sleep request and drops the clock enable of the main controller. The refresh logic and this block's own wake-up logic keep running.

Software can also hold the memory in self-refresh. While the hold is set, memory requests are back-pressured. When the hold is released, the block issues three steps in a fixed order: a self-refresh exit strobe, then one auto-refresh strobe, then the status bit is cleared. Only after that is the request channel opened again.

Requests arrive on a valid/ready pair. `req_ready` low is the only stall mechanism. A request is accepted in a cycle where both signals are high. The requester must hold `req_valid` until it is accepted. `req_ready` never depends on anything the requester drives in the same cycle except through the sleep state.

Top module: `sdram_pm_ctl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x07C00000. `req_ready` and `main_clk_en` are 1, and `sleep_req`, `sr_status` and the three strobes are 0.
- R2: A write stores `cfg_wdata[31:27]` as the idle count field CNT. On reads, bits 26:22 always return ones and bits 21:0 always return zeros, whatever was written to them.
- R3: With both enables high, after (CNT+1)*32 consecutive idle cycles, `sleep_req` goes to 1 and `main_clk_en` to 0 on the next clock edge, and not one cycle earlier.
- R4: If either `pm_en` or `ext_pm_en` is low, the idle count is held at zero and sleep is never entered.
- R5: A cycle with `req_valid` or `refresh_busy` high restarts the idle count from zero.
- R6: While asleep, `refresh_busy` does not wake the block: `sleep_req` stays 1 and `main_clk_en` stays 0.
- R7: While asleep, `req_valid` raises `main_clk_en` in the same cycle, with `req_ready` still 0. In the next cycle `sleep_req` is 0 and `req_ready` is 1. Dropping either enable also wakes the block.
- R8: While `sr_hold` is 1, `req_ready` is 0. The cycle after `sr_hold` is first seen, `sr_enter` pulses for one cycle and `sr_status` becomes 1.
- R9: One cycle after `sr_hold` falls, `sr_exit` pulses. One cycle later `auto_ref` pulses. One cycle after that, `sr_status` is 0 and `req_ready` is 1.
- R10: At most one of `sr_enter`, `sr_exit` and `auto_ref` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_en | input | 1 | Controller power-management enable bit |
| ext_pm_en | input | 1 | External power-management enable |
| sr_hold | input | 1 | Software self-refresh hold bit |
| refresh_busy | input | 1 | Refresh generator activity |
| cfg_wr | input | 1 | Idle-timer register write strobe |
| cfg_wdata | input | 32 | Idle-timer register write data |
| cfg_rdata | output | 32 | Idle-timer register read value |
| req_valid | input | 1 | Memory access request pending |
| req_ready | output | 1 | Request may be accepted |
| main_clk_en | output | 1 | Clock enable for the main controller |
| sleep_req | output | 1 | Sleep request / asleep indication |
| sr_enter | output | 1 | Self-refresh entry command strobe |
| sr_exit | output | 1 | Self-refresh exit command strobe |
| auto_ref | output | 1 | Auto-refresh command strobe |
| sr_status | output | 1 | Self-refresh in progress status |

## Verification
A wrong idle counter shows up as `sleep_req` rising early or late relative to the programmed threshold. The bench sees this exactly at cycle (CNT+1)*32 by checking one cycle before and at the threshold. A stuck or skipped sequencer state shows up as a missing or swapped strobe, or as `sr_status` or `req_ready` out of step. The bench observes this within one to three cycles of the `sr_hold` change. A faulty wake path shows up as `main_clk_en` staying low, or as `req_ready` rising, in the cycle the request arrives.

// File: rtl/sdram_pm_pkg.sv
package sdram_pm_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_SR_IN   = 3'd2,
    ST_SR_HOLD = 3'd3,
    ST_SR_EXIT = 3'd4,
    ST_AREF    = 3'd5
  } pm_state_e;
endpackage

// File: rtl/sdram_pm_idle_timer.sv
module sdram_pm_idle_timer #(
  parameter int REG_W     = 32,
  parameter int CNT_W     = 5,
  parameter int FIX_W     = 5,
  parameter int STEP_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             count_en,
  input  logic             restart,
  output logic [REG_W-1:0] rdata,
  output logic             expire
);
  localparam int TMR_W = CNT_W + STEP_LOG2;
  localparam int RSV_W = REG_W - CNT_W - FIX_W;

  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] idle_q;
  logic [TMR_W-1:0] limit;

  // (CNT+1)*2^STEP_LOG2 - 1 equals CNT followed by all-ones
  assign limit = {cnt_q, {STEP_LOG2{1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_en)  cnt_q <= wr_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !count_en || restart) idle_q <= '0;
    else if (idle_q != limit)           idle_q <= idle_q + 1'b1;
  end

  assign expire = count_en && !restart && (idle_q == limit);
  assign rdata  = {cnt_q, {FIX_W{1'b1}}, {RSV_W{1'b0}}};
endmodule

// File: rtl/sdram_pm_seq.sv
module sdram_pm_seq
  import sdram_pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sr_hold,
  input  logic      pm_ok,
  input  logic      req_valid,
  input  logic      expire,
  output pm_state_e state
);
  pm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:     if (sr_hold) nxt = ST_SR_IN;
                  else if (expire) nxt = ST_SLEEP;
      ST_SLEEP:   if (req_valid || sr_hold || !pm_ok) nxt = ST_RUN;
      ST_SR_IN:   nxt = ST_SR_HOLD;
      ST_SR_HOLD: if (!sr_hold) nxt = ST_SR_EXIT;
      ST_SR_EXIT: nxt = ST_AREF;
      ST_AREF:    nxt = ST_RUN;
      default:    nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/sdram_pm_ctl.sv
module sdram_pm_ctl
  import sdram_pm_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int CNT_W     = 5,
  parameter int FIX_W     = 5,
  parameter int STEP_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pm_en,
  input  logic             ext_pm_en,
  input  logic             sr_hold,
  input  logic             refresh_busy,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             main_clk_en,
  output logic             sleep_req,
  output logic             sr_enter,
  output logic             sr_exit,
  output logic             auto_ref,
  output logic             sr_status
);
  pm_state_e state;
  logic      pm_ok;
  logic      expire;
  logic      wake;

  assign pm_ok = pm_en && ext_pm_en;

  sdram_pm_idle_timer #(
    .REG_W(REG_W), .CNT_W(CNT_W), .FIX_W(FIX_W), .STEP_LOG2(STEP_LOG2)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_cnt   (cfg_wdata[REG_W-1 -: CNT_W]),
    .count_en (pm_ok && (state == ST_RUN)),
    .restart  (req_valid || refresh_busy),
    .rdata    (cfg_rdata),
    .expire   (expire)
  );

  sdram_pm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_hold   (sr_hold),
    .pm_ok     (pm_ok),
    .req_valid (req_valid),
    .expire    (expire),
    .state     (state)
  );

  assign wake        = req_valid || sr_hold || !pm_ok;
  assign main_clk_en = (state != ST_SLEEP) || wake;
  assign sleep_req   = (state == ST_SLEEP);
  assign req_ready   = (state == ST_RUN) && !sr_hold;
  assign sr_enter    = (state == ST_SR_IN);
  assign sr_exit     = (state == ST_SR_EXIT);
  assign auto_ref    = (state == ST_AREF);
  assign sr_status   = (state == ST_SR_IN) || (state == ST_SR_HOLD) ||
                       (state == ST_SR_EXIT) || (state == ST_AREF);
endmodule

// File: rtl/sdram_pm_chk.sv
module sdram_pm_chk (
  input logic clk,
  input logic rst_n,
  input logic pm_en,
  input logic ext_pm_en,
  input logic sr_hold,
  input logic req_valid,
  input logic req_ready,
  input logic main_clk_en,
  input logic sleep_req,
  input logic sr_enter,
  input logic sr_exit,
  input logic auto_ref,
  input logic sr_status
);
  p_stall_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_hold |-> !req_ready);

  p_enter_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_status) |-> sr_enter);

  p_exit_before_aref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> auto_ref);

  p_aref_then_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    auto_ref |=> !sr_status);

  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_enter, sr_exit, auto_ref}));

  p_wake_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && req_valid) |-> (main_clk_en && !req_ready));

  p_no_sleep_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_en && ext_pm_en) |=> !$rose(sleep_req));
endmodule

bind sdram_pm_ctl sdram_pm_chk u_chk (.*);

// File: tb/sdram_pm_ctl_bench.sv
module sdram_pm_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_en = 1'b0, ext_pm_en = 1'b0, sr_hold = 1'b0;
  logic        refresh_busy = 1'b0, cfg_wr = 1'b0, req_valid = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_ready, main_clk_en, sleep_req, sr_enter, sr_exit, auto_ref, sr_status;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sdram_pm_ctl u_sdram_pm_ctl (.*);

  // program word, expected read-back, expected idle threshold
  localparam logic [31:0] VW [0:2] = '{32'h0000_FFFF, 32'h0FFF_FFFF, 32'h1800_0001};
  localparam logic [31:0] VR [0:2] = '{32'h07C0_0000, 32'h0FC0_0000, 32'h1FC0_0000};
  localparam int          VT [0:2] = '{32, 64, 128};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [31:0] d);
    pm_en = 1'b0; cfg_wr = 1'b1; cfg_wdata = d;
    step(1);
    cfg_wr = 1'b0; cfg_wdata = '1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(cfg_rdata == 32'h07C0_0000, "R1 rdata", cfg_rdata, 32'h07C0_0000);
    chk(req_ready && main_clk_en, "R1 ready/clk", {req_ready, main_clk_en}, 2'b11);
    chk({sleep_req, sr_status, sr_enter, sr_exit, auto_ref} == 0, "R1 flags",
        {sleep_req, sr_status, sr_enter, sr_exit, auto_ref}, 0);

    // vector table: R2 register, R3 threshold, R7 wake
    for (int i = 0; i < 3; i++) begin
      wr_reg(VW[i]);
      chk(cfg_rdata == VR[i], "R2 readback", cfg_rdata, VR[i]);
      pm_en = 1'b1; ext_pm_en = 1'b1;
      step(VT[i] - 1);
      chk(!sleep_req, "R3 early", sleep_req, 0);
      step(1);
      chk(sleep_req && !main_clk_en, "R3 asleep", {sleep_req, main_clk_en}, 2'b10);
      req_valid = 1'b1; #1;
      chk(main_clk_en && !req_ready, "R7 same-cycle", {main_clk_en, req_ready}, 2'b10);
      step(1);
      chk(!sleep_req && req_ready, "R7 next-cycle", {sleep_req, req_ready}, 2'b01);
      req_valid = 1'b0;
    end

    // R4: either enable low blocks sleep
    wr_reg(32'h0);
    pm_en = 1'b1; ext_pm_en = 1'b0;
    step(100);
    chk(!sleep_req, "R4 ext low", sleep_req, 0);
    pm_en = 1'b0; ext_pm_en = 1'b1;
    step(100);
    chk(!sleep_req, "R4 pm low", sleep_req, 0);

    // R5: request restarts idle count
    pm_en = 1'b1;
    step(20);
    req_valid = 1'b1; step(1); req_valid = 1'b0;
    step(31);
    chk(!sleep_req, "R5 req restart", sleep_req, 0);
    step(1);
    chk(sleep_req, "R5 req sleep", sleep_req, 1);
    pm_en = 1'b0; step(1);
    chk(!sleep_req, "R7 disable wakes", sleep_req, 0);
    pm_en = 1'b1;
    step(20);
    refresh_busy = 1'b1; step(1); refresh_busy = 1'b0;
    step(31);
    chk(!sleep_req, "R5 refresh restart", sleep_req, 0);
    step(1);
    chk(sleep_req, "R5 refresh sleep", sleep_req, 1);

    // R6: refresh activity in sleep does not wake
    refresh_busy = 1'b1;
    step(3);
    chk(sleep_req && !main_clk_en, "R6 stay asleep", {sleep_req, main_clk_en}, 2'b10);
    refresh_busy = 1'b0;
    pm_en = 1'b0; step(1);

    // R8 / R9 / R10 self-refresh hold and exit order
    sr_hold = 1'b1; req_valid = 1'b1; #1;
    chk(!req_ready, "R8 stall", req_ready, 0);
    step(1);
    chk(sr_enter && sr_status && !req_ready, "R8 enter",
        {sr_enter, sr_status, req_ready}, 3'b110);
    step(1);
    chk(!sr_enter && sr_status, "R8 enter one cycle", {sr_enter, sr_status}, 2'b01);
    step(5);
    chk(!req_ready && sr_status, "R8 held", {req_ready, sr_status}, 2'b01);
    sr_hold = 1'b0; #1;
    chk(!req_ready, "R9 still stalled", req_ready, 0);
    step(1);
    chk({sr_enter, sr_exit, auto_ref, sr_status, req_ready} == 5'b01010, "R9 exit",
        {sr_enter, sr_exit, auto_ref, sr_status, req_ready}, 5'b01010);
    step(1);
    chk({sr_enter, sr_exit, auto_ref, sr_status, req_ready} == 5'b00110, "R9 aref R10",
        {sr_enter, sr_exit, auto_ref, sr_status, req_ready}, 5'b00110);
    step(1);
    chk({sr_exit, auto_ref, sr_status, req_ready} == 4'b0001, "R9 clear",
        {sr_exit, auto_ref, sr_status, req_ready}, 4'b0001);
    req_valid = 1'b0;
    step(2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule